// File: doc/BRIEF.md
# Load-Store Effective Address Generator

This block forms the memory address for fixed-point load and store operations of a 64-bit processor. From an already decoded operation form, an update flag, the number of the base register and the values read for it and for the index register, it adds either a displacement or the index value to a base. The displacement field is raw: the block itself clears the low bits that the scaled forms treat as implicit zeros, then sign-extends the field. In the two scaled forms the cleared low bits belong to other fields of the instruction.

When base register number 0 is named in a non-update form, the base is the constant zero rather than the register contents. Update forms always use the register value as the base, and they request a write-back of the computed address into that register. An update form that names register 0 is flagged as illegal, and its write-back is withheld. A parameter chooses between a purely combinational path and a path with one output register stage and a valid flag.

Top module: `ls_ea_gen`

## Requirements
- R1: Form code 0 (displacement): `ea` = base + sign-extended `disp_raw[15:0]`.
- R2: Form code 1 (word-scaled): `ea` = base + sign extension of {`disp_raw[15:2]`, 2'b00`}`; `disp_raw[1:0]` has no effect.
- R3: Form code 2 (quadword-scaled): `ea` = base + sign extension of {`disp_raw[15:4]`, 4'b0000`}`; `disp_raw[3:0]` has no effect.
- R4: Form code 3 (indexed): `ea` = base + `rb_val`; `disp_raw` has no effect.
- R5: With `op_update`=0 and `ra_num`=0 the base is zero and `ra_val` has no effect; with any other `ra_num` the base is `ra_val`.
- R6: With `op_update`=1 the base is always `ra_val`. If `ra_num`≠0, then `ra_we`=1 and `ra_wdata` equals `ea`.
- R7: With `op_update`=1 and `ra_num`=0, `illegal`=1 and `ra_we`=0. A non-update operation never raises `illegal`.
- R8: The addition wraps modulo 2^64.
- R9: With REGISTERED=1 (the default), the results for inputs sampled with `in_valid`=1 appear one clock later with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0, `ra_we`=0 and `illegal`=0 one clock later, while `ea` and `ra_wdata` hold their values.
- R10: While reset is asserted and after it is released, before any valid input, `out_valid`, `ra_we` and `illegal` are 0.
- R11: With REGISTERED=0 the outputs follow the inputs in the same cycle, `out_valid` equals `in_valid`, and `ra_we` and `illegal` are 0 whenever `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation is valid |
| op_form | input | 2 | Form: 0 displacement, 1 word-scaled, 2 quadword-scaled, 3 indexed |
| op_update | input | 1 | Operation writes the address back to the base register |
| ra_num | input | 5 | Base register number |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| disp_raw | input | 16 | Raw displacement field |
| out_valid | output | 1 | Outputs are valid |
| ea | output | 64 | Effective address |
| ra_we | output | 1 | Write-back enable for the base register |
| ra_wdata | output | 64 | Value written back to the base register |
| illegal | output | 1 | Update form names register 0 |

## Verification
Each form is driven with positive and negative displacements whose low bits are set, so that a missing clear or a clear of the wrong width in the scaled forms changes the address. Register number 0 is tried with and without update and with a non-zero `ra_val`, which separates the zero-base rule from the update rule and from the illegal flag. Sums that cross 2^64 check the wrap. Idle cycles between operations check the hold of the address and the clearing of the flags, and a combinational instance is checked in the same cycle as its inputs.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  typedef enum logic [1:0] {
    FORM_D  = 2'd0,
    FORM_DS = 2'd1,
    FORM_DQ = 2'd2,
    FORM_X  = 2'd3
  } form_e;
endpackage

// File: rtl/lsag_base.sv
module lsag_base #(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input  logic            op_update,
  input  logic [REGW-1:0] ra_num,
  input  logic [XLEN-1:0] ra_val,
  output logic [XLEN-1:0] base,
  output logic            ra_is_zero
);
  always_comb begin
    ra_is_zero = (ra_num == '0);
    if (!op_update && ra_is_zero) base = '0;
    else                          base = ra_val;
  end
endmodule

// File: rtl/lsag_disp.sv
module lsag_disp
  import lsag_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int DISPW = 16,
  parameter int DS_ZB = 2,
  parameter int DQ_ZB = 4
) (
  input  form_e            form,
  input  logic [DISPW-1:0] disp_raw,
  input  logic [XLEN-1:0]  rb_val,
  output logic [XLEN-1:0]  offset
);
  localparam logic [DISPW-1:0] DS_MASK = ~((DISPW'(1) << DS_ZB) - DISPW'(1));
  localparam logic [DISPW-1:0] DQ_MASK = ~((DISPW'(1) << DQ_ZB) - DISPW'(1));

  logic [DISPW-1:0] field;

  always_comb begin
    unique case (form)
      FORM_DS: field = disp_raw & DS_MASK;
      FORM_DQ: field = disp_raw & DQ_MASK;
      default: field = disp_raw;
    endcase
    if (form == FORM_X) offset = rb_val;
    else                offset = {{(XLEN-DISPW){field[DISPW-1]}}, field};
  end
endmodule

// File: rtl/lsag_ostage.sv
module lsag_ostage #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [XLEN-1:0] ea_i,
  input  logic            we_i,
  input  logic            ill_i,
  output logic            valid_o,
  output logic [XLEN-1:0] ea_o,
  output logic            we_o,
  output logic            ill_o
);
  logic            valid_d, we_d, ill_d;
  logic [XLEN-1:0] ea_d;

  always_comb begin
    valid_d = valid_i;
    we_d    = valid_i & we_i;
    ill_d   = valid_i & ill_i;
    ea_d    = valid_i ? ea_i : ea_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      we_o    <= 1'b0;
      ill_o   <= 1'b0;
    end else begin
      valid_o <= valid_d;
      we_o    <= we_d;
      ill_o   <= ill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (valid_i) ea_o <= ea_d;
  end

  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (valid_o == $past(valid_i)));

  assert_ea_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(ea_o));

  assert_flags_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!we_o && !ill_o));
endmodule

// File: rtl/ls_ea_gen.sv
module ls_ea_gen
  import lsag_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int REGW       = 5,
  parameter int DISPW      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_form,
  input  logic             op_update,
  input  logic [REGW-1:0]  ra_num,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  rb_val,
  input  logic [DISPW-1:0] disp_raw,
  output logic             out_valid,
  output logic [XLEN-1:0]  ea,
  output logic             ra_we,
  output logic [XLEN-1:0]  ra_wdata,
  output logic             illegal
);
  form_e           form;
  logic [XLEN-1:0] base, offset, ea_c;
  logic            ra_is_zero, we_c, ill_c;

  assign form = form_e'(op_form);

  lsag_base #(.XLEN(XLEN), .REGW(REGW)) u_base (
    .op_update (op_update),
    .ra_num    (ra_num),
    .ra_val    (ra_val),
    .base      (base),
    .ra_is_zero(ra_is_zero)
  );

  lsag_disp #(.XLEN(XLEN), .DISPW(DISPW)) u_disp (
    .form    (form),
    .disp_raw(disp_raw),
    .rb_val  (rb_val),
    .offset  (offset)
  );

  always_comb begin
    ea_c  = base + offset;
    we_c  = op_update & ~ra_is_zero;
    ill_c = op_update &  ra_is_zero;
  end

  generate
    if (REGISTERED) begin : g_reg
      lsag_ostage #(.XLEN(XLEN)) u_ostage (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(in_valid),
        .ea_i   (ea_c),
        .we_i   (we_c),
        .ill_i  (ill_c),
        .valid_o(out_valid),
        .ea_o   (ea),
        .we_o   (ra_we),
        .ill_o  (illegal)
      );
    end else begin : g_comb
      assign out_valid = in_valid;
      assign ea        = ea_c;
      assign ra_we     = in_valid & we_c;
      assign illegal   = in_valid & ill_c;
    end
  endgenerate

  assign ra_wdata = ea;

  always_comb begin
    if (rst_n) begin
      assert_no_we_when_illegal_R7: assert (!(we_c && ill_c));
      if (!op_update && ra_num == '0 && form == FORM_X)
        assert_zero_base_index_R5: assert (ea_c == rb_val);
      if (op_update && form == FORM_X)
        assert_update_base_R6: assert (ea_c == ra_val + rb_val);
    end
  end
endmodule

// File: tb/ls_ea_gen_test.sv
`timescale 1ns/1ps
module ls_ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_form;
  logic        op_update;
  logic [4:0]  ra_num;
  logic [63:0] ra_val, rb_val;
  logic [15:0] disp_raw;

  logic        ov_r, we_r, il_r, ov_c, we_c, il_c;
  logic [63:0] ea_r, wd_r, ea_c, wd_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] last_ea;

  always #2 clk = ~clk;

  ls_ea_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_form(op_form),
    .op_update(op_update), .ra_num(ra_num), .ra_val(ra_val), .rb_val(rb_val),
    .disp_raw(disp_raw), .out_valid(ov_r), .ea(ea_r), .ra_we(we_r),
    .ra_wdata(wd_r), .illegal(il_r)
  );

  ls_ea_gen #(.REGISTERED(1'b0)) uut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_form(op_form),
    .op_update(op_update), .ra_num(ra_num), .ra_val(ra_val), .rb_val(rb_val),
    .disp_raw(disp_raw), .out_valid(ov_c), .ea(ea_c), .ra_we(we_c),
    .ra_wdata(wd_c), .illegal(il_c)
  );

  // Behavioural reference: signed arithmetic on the displacement.
  function automatic void model(input logic v, input logic [1:0] f, input logic u,
                                input logic [4:0] rn, input logic [63:0] rav,
                                input logic [63:0] rbv, input logic [15:0] d,
                                output logic [63:0] e, output logic w, output logic il);
    longint b, off;
    b = (u || rn != 0) ? longint'(rav) : 64'sd0;
    case (f)
      2'd0: off = longint'(shortint'(d));
      2'd1: off = longint'(shortint'(d)) / 4 * 4 - ((d[15] && d[1:0] != 0) ? 4 : 0);
      2'd2: off = longint'(shortint'(d)) / 16 * 16 - ((d[15] && d[3:0] != 0) ? 16 : 0);
      default: off = longint'(rbv);
    endcase
    e  = 64'(b + off);
    w  = v && u && rn != 0;
    il = v && u && rn == 0;
  endfunction

  task automatic cmp(input string req, input string inst, input logic ov, input logic [63:0] e,
                     input logic w, input logic [63:0] wd, input logic il,
                     input logic xov, input logic [63:0] xe, input logic xw, input logic xil);
    checks++;
    if (ov !== xov || e !== xe || w !== xw || wd !== xe || il !== xil) begin
      fails++;
      $display("FAIL %s %s: got v=%0b ea=%h we=%0b wd=%h ill=%0b exp v=%0b ea=%h we=%0b ill=%0b",
               req, inst, ov, e, w, wd, il, xov, xe, xw, xil);
    end
  endtask

  // Called at a falling edge: drive, check combinational copy, check registered copy next fall.
  task automatic op(input string req, input logic v, input logic [1:0] f, input logic u,
                    input logic [4:0] rn, input logic [63:0] rav, input logic [63:0] rbv,
                    input logic [15:0] d);
    logic [63:0] xe;
    logic xw, xil;
    in_valid = v; op_form = f; op_update = u; ra_num = rn;
    ra_val = rav; rb_val = rbv; disp_raw = d;
    model(v, f, u, rn, rav, rbv, d, xe, xw, xil);
    #1;
    if (v) cmp(req, "comb", ov_c, ea_c, we_c, wd_c, il_c, 1'b1, xe, xw, xil);
    else begin
      checks++;
      if (ov_c !== 1'b0 || we_c !== 1'b0 || il_c !== 1'b0) begin
        fails++;
        $display("FAIL R11 comb idle: got v=%0b we=%0b ill=%0b exp 0 0 0", ov_c, we_c, il_c);
      end
    end
    if (v) last_ea = xe;
    @(negedge clk);
    cmp(req, "reg", ov_r, ea_r, we_r, wd_r, il_r, v, last_ea, xw, xil);
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_form = 2'd0; op_update = 1'b0;
    ra_num = 5'd0; ra_val = '0; rb_val = '0; disp_raw = '0;
    last_ea = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (ov_r !== 1'b0 || we_r !== 1'b0 || il_r !== 1'b0) begin
      fails++;
      $display("FAIL R10 in reset: got v=%0b we=%0b ill=%0b exp 0 0 0", ov_r, we_r, il_r);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (ov_r !== 1'b0 || we_r !== 1'b0 || il_r !== 1'b0) begin
      fails++;
      $display("FAIL R10 after release: got v=%0b we=%0b ill=%0b exp 0 0 0", ov_r, we_r, il_r);
    end

    op("R1 pos disp",  1, 2'd0, 0, 5'd3, 64'h0000_1000_0000_0000, 64'hdead, 16'h1237);
    op("R1 neg disp",  1, 2'd0, 0, 5'd3, 64'h0000_1000_0000_0000, 64'hdead, 16'h8001);
    op("R2 pos ds",    1, 2'd1, 0, 5'd7, 64'h4000, 64'h0, 16'h1237);
    op("R2 neg ds",    1, 2'd1, 0, 5'd7, 64'h4000, 64'h0, 16'hFFFF);
    op("R3 pos dq",    1, 2'd2, 0, 5'd9, 64'h8000, 64'h0, 16'h7FFF);
    op("R3 neg dq",    1, 2'd2, 0, 5'd9, 64'h8000, 64'h0, 16'hF00F);
    op("R4 indexed",   1, 2'd3, 0, 5'd2, 64'h1111_0000, 64'h0000_2222, 16'hFFFF);
    op("R5 zero base d",  1, 2'd0, 0, 5'd0, 64'hFFFF_0000_1234_5678, 64'h0, 16'h0040);
    op("R5 zero base x",  1, 2'd3, 0, 5'd0, 64'hFFFF_0000_1234_5678, 64'h0000_0abc, 16'h0);
    op("R5 nonzero reg",  1, 2'd0, 0, 5'd31, 64'h0000_0000_0000_0100, 64'h0, 16'h0000);
    op("R6 update d",  1, 2'd0, 1, 5'd4, 64'h2000, 64'h0, 16'hFFF8);
    op("R6 update x",  1, 2'd3, 1, 5'd5, 64'h2000, 64'h30, 16'h0);
    op("R6 update dq", 1, 2'd2, 1, 5'd6, 64'h2000, 64'h0, 16'h0013);
    op("R9 idle hold", 0, 2'd3, 1, 5'd5, 64'h9999, 64'h7777, 16'h5555);
    op("R9 idle hold2",0, 2'd0, 1, 5'd0, 64'h1, 64'h1, 16'h1);
    op("R7 update r0", 1, 2'd0, 1, 5'd0, 64'h5000, 64'h0, 16'h0010);
    op("R7 update r0 x", 1, 2'd3, 1, 5'd0, 64'h5000, 64'h10, 16'h0);
    op("R8 wrap up",   1, 2'd3, 0, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0);
    op("R8 wrap down", 1, 2'd0, 0, 5'd1, 64'h0000_0000_0000_0004, 64'h0, 16'h8000);
    op("R8 wrap ds",   1, 2'd1, 1, 5'd8, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 16'h0007);
    for (int i = 0; i < 40; i++) begin
      op("R1 R2 R3 R4 R6 sweep", (i % 5) != 4, 2'(i), i[3], 5'(i * 7),
         {32'(i * 32'h9E37_79B9), 32'(i * 32'h85EB_CA6B)},
         {32'(i * 32'hC2B2_AE35), 32'(~i)}, 16'(i * 16'h3A57));
    end
    op("R11 idle comb", 0, 2'd1, 0, 5'd3, 64'h0, 64'h0, 16'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule